// File: doc/BRIEF.md
# Hybrid Counter and Tap-Chain Pulse-Width Modulator

This block produces a single pulse-width modulated output whose duty resolution is finer than one period of a coarse counter. The duty command is split in two. The upper bits are compared against a coarse counter that advances once for each full revolution of a short tap ring. The lower bits pick one position of that ring, and the ring subdivides each coarse step. In silicon the ring would be a chain of delay cells. Here it is a one-hot token that moves one position on every stage advance, so the block can be synthesized and simulated as ordinary synchronous logic.

A stage advance comes from a fine-step enable, divided by a dwell that the frequency-select input sets. The dwell changes the length of a stage, and so the switching period, without changing the duty resolution. The output latch is set at the start of each period and cleared when the position reaches the captured duty value. A command of zero never sets the latch. A full-scale command never clears it. The duty word is sampled only at a period boundary.

With the default parameters, an 8-bit command is split into 3 counter bits and 5 ring bits. The coarse counter therefore advances only once every 32 stages.

Top module: `hybrid_dpwm`

## Requirements
- R1: A synchronous reset drives `pwm_out` low one clock later. The output stays low through the whole first period after reset. That period is 2^N_BITS stage advances long, starting from stage 0.
- R2: A stage advance happens once every 2^`fsel` clock cycles in which `fine_step` is high. For a 2-bit select the dwells are 1, 2, 4 and 8. Cycles with `fine_step` low never advance the stage.
- R3: A period lasts exactly 2^N_BITS stage advances. A new period starts on the advance that leaves the last stage, 2^N_BITS-1.
- R4: When the captured duty value k is not zero, `pwm_out` is high in the clock after stage 0 begins.
- R5: For 1 <= k <= 2^N_BITS-2, `pwm_out` goes low in the clock after stage k begins. The output is therefore high for exactly k stages of every period.
- R6: A captured duty of zero (all bits clear) keeps `pwm_out` low for the whole period.
- R7: A captured duty of all ones keeps `pwm_out` high for the whole period, with no low pulse inside it.
- R8: `duty` is sampled only on the advance that starts a period. A change at any other time has no effect on `pwm_out` until the next period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fine_step | input | 1 | Fine-step enable that moves the tap token |
| fsel | input | FSEL_W | Dwell select; stage length = 2^fsel fine steps |
| duty | input | N_BITS | Duty command, sampled at each period start |
| pwm_out | output | 1 | Modulated output from the set/clear latch |

## Verification
Two functions can fall in the same cycle. The first pair is the set and the clear of the output latch: with a zero command, both conditions are true at stage 0, and the clear has to win. The bench provokes this by switching from a full-scale command straight to zero, and checks that the output falls at the first period boundary and stays low for the whole period. The second pair is the period-start capture and a change on `duty`. The bench toggles the command every few dozen cycles, so some changes land on the capture edge itself. An independent stage model in the bench, fed the same inputs, predicts the output for every cycle. Each prediction is queued and then compared against the pin.

// File: rtl/hdpwm_pkg.sv
package hdpwm_pkg;
   // Action applied to the output latch in one cycle
   typedef enum logic [1:0] {
      LATCH_HOLD = 2'd0,
      LATCH_SET  = 2'd1,
      LATCH_CLR  = 2'd2
   } latch_act_e;
endpackage

// File: rtl/hdpwm_step_gen.sv
module hdpwm_step_gen #(
   parameter int FSEL_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fine_step,
   input  logic [FSEL_W-1:0] fsel,
   output logic              adv
);
   localparam int DW_W = (1 << FSEL_W) - 1;

   generate
      if (FSEL_W < 1 || FSEL_W > 4) begin : g_bad_fsel
         $error("hdpwm_step_gen: FSEL_W must be in 1..4");
      end
   endgenerate

   logic [DW_W-1:0] dw_q;
   logic [DW_W-1:0] lim;

   // Dwell limit = 2^fsel - 1, computed with modular arithmetic
   assign lim = ({{(DW_W-1){1'b0}}, 1'b1} << fsel) - {{(DW_W-1){1'b0}}, 1'b1};
   assign adv = fine_step && (dw_q >= lim);

   always_ff @(posedge clk) begin
      if (rst)            dw_q <= '0;
      else if (adv)       dw_q <= '0;
      else if (fine_step) dw_q <= dw_q + {{(DW_W-1){1'b0}}, 1'b1};
   end

   // R2: the dwell count does not move without a fine step
   a_r2_dwell_idle: assert property (@(posedge clk) disable iff (rst)
      !fine_step |=> $stable(dw_q));
endmodule

// File: rtl/hdpwm_tap_ring.sv
module hdpwm_tap_ring #(
   parameter int ND = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   input  logic [ND-1:0] sel,
   output logic          at_first,
   output logic          wrap,
   output logic          sel_hit
);
   localparam int TAPS = 1 << ND;

   generate
      if (ND < 1) begin : g_bad_nd
         $error("hdpwm_tap_ring: ND must be at least 1");
      end
   endgenerate

   logic [TAPS-1:0] tap_q;
   logic [TAPS-1:0] tap_d;

   // One-hot token ring: each position takes the token from its predecessor
   genvar gi;
   generate
      for (gi = 0; gi < TAPS; gi++) begin : g_stage
         if (gi == 0) begin : g_head
            assign tap_d[gi] = tap_q[TAPS-1];
         end else begin : g_body
            assign tap_d[gi] = tap_q[gi-1];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)      tap_q <= {{(TAPS-1){1'b0}}, 1'b1};
      else if (adv) tap_q <= tap_d;
   end

   assign at_first = tap_q[0];
   assign wrap     = adv && tap_q[TAPS-1];
   assign sel_hit  = tap_q[sel];

   // R3: exactly one token in the ring at all times
   a_r3_one_token: assert property (@(posedge clk) disable iff (rst)
      $countones(tap_q) == 1);
   // R2: the token moves only on a stage advance
   a_r2_ring_hold: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(tap_q));
endmodule

// File: rtl/hdpwm_coarse_cnt.sv
module hdpwm_coarse_cnt #(
   parameter int NC = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          inc,
   output logic [NC-1:0] cnt_q,
   output logic          at_max
);
   generate
      if (NC < 1) begin : g_bad_nc
         $error("hdpwm_coarse_cnt: NC must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)      cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + NC'(1);
   end

   assign at_max = &cnt_q;

   // R3: the counter moves only when the ring wraps, by one each time
   a_r3_cnt_hold: assert property (@(posedge clk) disable iff (rst)
      !inc |=> $stable(cnt_q));
   a_r3_cnt_step: assert property (@(posedge clk) disable iff (rst)
      inc |=> cnt_q == $past(cnt_q) + NC'(1));
endmodule

// File: rtl/hybrid_dpwm.sv
module hybrid_dpwm #(
   parameter int N_BITS = 8,
   parameter int NC     = 3,
   parameter int FSEL_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fine_step,
   input  logic [FSEL_W-1:0] fsel,
   input  logic [N_BITS-1:0] duty,
   output logic              pwm_out
);
   import hdpwm_pkg::*;

   localparam int ND = N_BITS - NC;
   localparam logic [N_BITS-1:0] FULL = {N_BITS{1'b1}};

   generate
      if (NC < 1 || ND < 1) begin : g_bad_split
         $error("hybrid_dpwm: need 1 <= NC < N_BITS");
      end
   endgenerate

   logic              adv, wrap, at_first, sel_hit, at_max, pstart;
   logic [NC-1:0]     cnt;
   logic [N_BITS-1:0] duty_q;
   logic              pwm_q;
   logic              coarse_match, is_full, is_zero;
   latch_act_e        act;

   hdpwm_step_gen #(.FSEL_W(FSEL_W)) u_step (
      .clk(clk), .rst(rst), .fine_step(fine_step), .fsel(fsel), .adv(adv));

   hdpwm_tap_ring #(.ND(ND)) u_ring (
      .clk(clk), .rst(rst), .adv(adv), .sel(duty_q[ND-1:0]),
      .at_first(at_first), .wrap(wrap), .sel_hit(sel_hit));

   hdpwm_coarse_cnt #(.NC(NC)) u_coarse (
      .clk(clk), .rst(rst), .inc(wrap), .cnt_q(cnt), .at_max(at_max));

   // Period boundary: the ring wraps while the coarse counter is at its top
   assign pstart       = wrap && at_max;
   assign coarse_match = (cnt == duty_q[N_BITS-1:ND]);
   assign is_full      = &duty_q;
   assign is_zero      = ~|duty_q;

   // Clear has priority so a zero command stays low at stage 0
   always_comb begin
      act = LATCH_HOLD;
      if (coarse_match && sel_hit && !is_full)        act = LATCH_CLR;
      else if (cnt == '0 && at_first && !is_zero)     act = LATCH_SET;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         duty_q <= '0;
         pwm_q  <= 1'b0;
      end else begin
         if (pstart) duty_q <= duty;
         case (act)
            LATCH_SET: pwm_q <= 1'b1;
            LATCH_CLR: pwm_q <= 1'b0;
            default:   pwm_q <= pwm_q;
         endcase
      end
   end

   assign pwm_out = pwm_q;

   // R1: output low right after reset
   a_r1_reset_low: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !pwm_q);
   // R8: duty register changes only at a period start
   a_r8_duty_hold: assert property (@(posedge clk) disable iff (rst)
      !pstart |=> $stable(duty_q));
   // R6: no rising edge while the captured command is zero
   a_r6_zero_no_rise: assert property (@(posedge clk) disable iff (rst)
      $rose(pwm_q) |-> duty_q != '0);
   // R7: no falling edge caused by a full-scale command
   a_r7_full_no_fall: assert property (@(posedge clk) disable iff (rst)
      $fell(pwm_q) |-> $past(duty_q) != FULL);
endmodule

// File: tb/hybrid_dpwm_bench.sv
module hybrid_dpwm_bench;
   localparam int N_BITS = 8;
   localparam int NC     = 3;
   localparam int FSEL_W = 2;
   localparam int STAGES = 1 << N_BITS;
   localparam int FULLV  = STAGES - 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic fine_step = 1'b1;
   logic [FSEL_W-1:0] fsel = '0;
   logic [N_BITS-1:0] duty = '0;
   logic pwm_out;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;
   string cur_tag = "R1";

   bit    exp_q[$];
   string tag_q[$];

   // model state
   int s = 0;
   int dw = 0;
   int dq = 0;

   hybrid_dpwm #(.N_BITS(N_BITS), .NC(NC), .FSEL_W(FSEL_W)) u_hybrid_dpwm (
      .clk(clk), .rst(rst), .fine_step(fine_step), .fsel(fsel),
      .duty(duty), .pwm_out(pwm_out));

   always #5 clk = ~clk;

   task automatic check(bit ok, string tg, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tg, act, expv, cyc);
      end
   endtask

   // Driver side: reference stage model pushes the expected output
   always @(posedge clk) begin
      bit a;
      cyc++;
      if (rst) begin
         exp_q.push_back(1'b0);
         tag_q.push_back(cur_tag);
         s = 0; dw = 0; dq = 0;
      end else begin
         exp_q.push_back((dq == FULLV) ? 1'b1 : (s < dq));
         tag_q.push_back(cur_tag);
         a = 1'b0;
         if (fine_step) begin
            if (dw >= (1 << fsel) - 1) begin dw = 0; a = 1'b1; end
            else dw++;
         end
         if (a) begin
            if (s == STAGES - 1) begin s = 0; dq = int'(duty); end
            else s++;
         end
      end
   end

   // Monitor: pop and compare away from the active edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         bit e;
         string tg;
         e  = exp_q.pop_front();
         tg = tag_q.pop_front();
         check(pwm_out === e, tg, int'(pwm_out), int'(e));
      end
   end

   // Watchdog
   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic run(string tg, int dv, int fs, bit gap, int cycles);
      cur_tag = tg;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         duty = N_BITS'(dv);
         fsel = FSEL_W'(fs);
         fine_step = gap ? i[0] : 1'b1;
      end
   endtask

   task automatic measure(string tg, int expv);
      int first;
      int second;
      logic prev;
      first = -1; second = -1;
      cur_tag = tg;
      @(negedge clk);
      prev = pwm_out;
      for (int i = 0; i < 3 * expv + 10; i++) begin
         @(negedge clk);
         if (pwm_out && !prev) begin
            if (first < 0) first = cyc;
            else if (second < 0) second = cyc;
         end
         prev = pwm_out;
      end
      check(second - first == expv, tg, second - first, expv);
   endtask

   initial begin
      // R1: reset with a nonzero command waiting
      rst = 1'b1; duty = 8'd100; fine_step = 1'b1; fsel = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      run("R1", 100, 0, 1'b0, 255);
      // R4, R5: steady command
      run("R4,R5", 100, 0, 1'b0, 600);
      // R5 boundaries
      run("R5_min", 1, 0, 1'b0, 600);
      run("R5_max", 254, 0, 1'b0, 600);
      // R7 full scale, then R6 zero directly after it (set/clear collision)
      run("R7", 255, 0, 1'b0, 600);
      run("R6", 0, 0, 1'b0, 600);
      run("R4,R5", 37, 0, 1'b0, 600);
      // R8: command changes mid-period, some landing on the capture edge
      for (int k = 0; k < 40; k++)
         run("R8", (k % 2) ? 60 : 200, 0, 1'b0, 37);
      // R3: period length at dwell 1
      run("R3", 100, 0, 1'b0, 10);
      measure("R3", STAGES);
      // R2: longer dwells and gapped fine steps
      run("R2", 64, 1, 1'b0, 1200);
      measure("R2", 2 * STAGES);
      run("R2", 64, 3, 1'b1, 4200);
      run("R2", 180, 2, 1'b1, 4200);
      // R1: reset in the middle of a high phase
      run("R1", 200, 0, 1'b0, 300);
      cur_tag = "R1";
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      run("R1", 200, 0, 1'b0, 300);
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule